// File: doc/BRIEF.md
# Register-List Block Transfer Sequencer

This block runs the memory side of stack push, stack pop and multi-word load/store operations on the eight low general registers. A decoder hands it one operation, an 8-bit register mask, an extra-register flag, a base register number and the current base and program counter values. The block then walks the mask in the order the operation needs. It issues one 32-bit word request per register on a valid/ready memory port. It reads store data through a register-file read port and returns loaded words and the final base value through a register-file write port.

Each bus access is tagged as nonsequential (the first of the transfer) or sequential (all others). Load operations end with a single internal cycle before the base writeback. Loading the program counter raises a one-cycle flush pulse for the pipeline logic outside the block. An empty mask on the multi-word forms moves the program counter instead and steps the base by 64 bytes.

Top module: `blkxfer_seq`

## Requirements
- R1: After synchronous reset, `busy`, `mem_valid`, `rf_we`, `flush` and `icyc` are all low.
- R2: Push (`op`=00) stores the link register (register index 14) first when `xtra` is set, then the listed registers from index 7 down to 0. Each word goes to (SP-4k) with the low two bits cleared, where k counts the words so far (1, 2, ...). SP (index 13) is written back as `base_val` minus 4 per word, with no alignment.
- R3: Pop (`op`=01) loads the listed registers from index 0 up to 7, from `base_val` with its low two bits cleared and ascending by 4. SP (index 13) is written back as that aligned start plus 4 per word. With nothing to pop, SP is written back unchanged.
- R4: When pop has `xtra` set, the program counter (index 15) is loaded last with bit 0 cleared, and `flush` pulses in the same cycle as that register write.
- R5: Store-multiple (`op`=10) and load-multiple (`op`=11) start at `base_val` with its low two bits cleared and step up by 4 per listed register in ascending index order. The base register named by `base_idx` is written back as the aligned start plus 4 per word. Every request address has its low two bits at zero.
- R6: On load-multiple, when the mask bit at `base_idx` is set, no base writeback happens and the loaded value stays in that register.
- R7: With an all-zero mask, load-multiple reads one word at the aligned base into the program counter (index 15) with bit 0 cleared and pulses `flush`. Store-multiple writes `pc_val`+2 at the aligned base. Both write the base back as the aligned base plus 64.
- R8: The first memory access of a transfer has `mem_seq` low, and every later access of the same transfer has `mem_seq` high.
- R9: Loads that made at least one access produce exactly one cycle of `icyc` after the last access and before the base writeback. Stores produce none.
- R10: While `mem_valid` is high and `mem_ready` is low, address, write data and write enable stay constant. Every listed register is transferred exactly once, whatever the stall pattern.
- R11: `busy` rises in the cycle after `start` is accepted and stays high through the base writeback cycle. A `start` pulse while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Accept an operation when idle |
| op | input | 2 | 00 push, 01 pop, 10 store-multiple, 11 load-multiple |
| reg_list | input | 8 | Register mask, bit n selects register n |
| xtra | input | 1 | Push: also store LR; pop: also load PC |
| base_idx | input | 3 | Base register for multi-word forms |
| base_val | input | XLEN | Current SP or base register value |
| pc_val | input | XLEN | Current program counter value |
| busy | output | 1 | Operation in progress |
| mem_valid | output | 1 | Memory request valid |
| mem_we | output | 1 | Request is a write |
| mem_seq | output | 1 | 0 nonsequential, 1 sequential access |
| mem_addr | output | XLEN | Word address of request |
| mem_wdata | output | XLEN | Store data |
| mem_ready | input | 1 | Memory accepts the request |
| mem_rdata | input | XLEN | Load data, valid with ready |
| rf_rd_idx | output | 4 | Register-file read index |
| rf_rd_data | input | XLEN | Register-file read data (combinational) |
| rf_we | output | 1 | Register-file write strobe |
| rf_wr_idx | output | 4 | Register-file write index |
| rf_wr_data | output | XLEN | Register-file write data |
| flush | output | 1 | Program counter loaded, pipeline refill needed |
| icyc | output | 1 | Internal cycle of a load |

## Verification
The directed tests go after the ordering corners. A push that walked the mask upward, or that did not start with the link register, would store words at the wrong addresses. A pop that forgot to clear bit 0 of a loaded program counter would write an odd value, and one that skipped the flush would leave a stale pipeline. A load-multiple that ignored the base-in-list rule would overwrite the freshly loaded base. An empty mask handled as a no-op would leave the base unchanged instead of adding 64, and would store or load nothing. An unaligned stack pointer on push and a stalling memory test the address masking and check that no register is skipped or repeated while ready is low.

// File: rtl/blkxfer_pkg.sv
package blkxfer_pkg;
  localparam int unsigned NLOW  = 8;          // low registers covered by the mask
  localparam int unsigned NSLOT = NLOW + 2;   // + extra register slot + empty-mask slot
  localparam int unsigned SLW   = $clog2(NSLOT);

  localparam logic [3:0] IDX_SP = 4'd13;
  localparam logic [3:0] IDX_LR = 4'd14;
  localparam logic [3:0] IDX_PC = 4'd15;

  typedef enum logic [1:0] {
    OP_PUSH = 2'b00,
    OP_POP  = 2'b01,
    OP_STM  = 2'b10,
    OP_LDM  = 2'b11
  } xop_e;

  typedef enum logic [2:0] {
    S_IDLE, S_SEL, S_ISSUE, S_BUS, S_ICYC, S_FIN, S_DONE
  } xst_e;

  // Map a work slot to a register index for the given operation.
  function automatic logic [3:0] slot_reg(input logic [SLW-1:0] s, input xop_e o);
    if (s < SLW'(NLOW)) return s[3:0];
    if (s == SLW'(NLOW) && o == OP_PUSH) return IDX_LR;
    return IDX_PC;
  endfunction
endpackage

// File: rtl/blkxfer_pick.sv
// Priority picker over the pending slots; direction chosen at run time.
module blkxfer_pick #(
  parameter int unsigned N  = 10,
  parameter int unsigned IW = $clog2(N)
) (
  input  logic [N-1:0]  pend,
  input  logic          down,
  output logic          any,
  output logic [IW-1:0] idx
);
  always_comb begin
    any = |pend;
    idx = '0;
    if (down) begin
      for (int i = 0; i < N; i++)
        if (pend[i]) idx = IW'(i);       // highest set bit wins
    end else begin
      for (int i = N - 1; i >= 0; i--)
        if (pend[i]) idx = IW'(i);       // lowest set bit wins
    end
  end
endmodule

// File: rtl/blkxfer_addr.sv
// Access address and next running pointer for one word.
module blkxfer_addr
  import blkxfer_pkg::*;
#(
  parameter int unsigned XLEN       = 32,
  parameter int unsigned STEP       = 4,
  parameter int unsigned EMPTY_STEP = 64
) (
  input  xop_e            op,
  input  logic [XLEN-1:0] ptr,
  input  logic            empty_slot,
  output logic [XLEN-1:0] acc_addr,
  output logic [XLEN-1:0] ptr_nxt
);
  localparam logic [XLEN-1:0] AMASK = ~XLEN'(STEP - 1);

  logic [XLEN-1:0] dec, al;

  always_comb begin
    dec = ptr - XLEN'(STEP);
    al  = ptr & AMASK;
    if (op == OP_PUSH) begin
      acc_addr = dec & AMASK;
      ptr_nxt  = dec;
    end else begin
      acc_addr = al;
      ptr_nxt  = al + (empty_slot ? XLEN'(EMPTY_STEP) : XLEN'(STEP));
    end
  end
endmodule

// File: rtl/blkxfer_seq.sv
module blkxfer_seq
  import blkxfer_pkg::*;
#(
  parameter int unsigned XLEN = 32,
  parameter int unsigned RIW  = 4,
  parameter int unsigned BIW  = $clog2(NLOW)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  input  logic [1:0]      op,
  input  logic [NLOW-1:0] reg_list,
  input  logic            xtra,
  input  logic [BIW-1:0]  base_idx,
  input  logic [XLEN-1:0] base_val,
  input  logic [XLEN-1:0] pc_val,
  output logic            busy,
  output logic            mem_valid,
  output logic            mem_we,
  output logic            mem_seq,
  output logic [XLEN-1:0] mem_addr,
  output logic [XLEN-1:0] mem_wdata,
  input  logic            mem_ready,
  input  logic [XLEN-1:0] mem_rdata,
  output logic [RIW-1:0]  rf_rd_idx,
  input  logic [XLEN-1:0] rf_rd_data,
  output logic            rf_we,
  output logic [RIW-1:0]  rf_wr_idx,
  output logic [XLEN-1:0] rf_wr_data,
  output logic            flush,
  output logic            icyc
);
  xst_e             st;
  xop_e             op_q;
  logic [NSLOT-1:0] pend, pend_init;
  logic [XLEN-1:0]  ptr, pc_q;
  logic             first_q, wb_en_q;
  logic [RIW-1:0]   wb_idx_q;
  logic [SLW-1:0]   slot_q;

  logic             pick_any;
  logic [SLW-1:0]   pick_idx;
  logic [XLEN-1:0]  acc_addr, ptr_nxt;
  logic             is_ld, empty_slot;
  logic [3:0]       cur_reg;

  assign is_ld      = (op_q == OP_POP) || (op_q == OP_LDM);
  assign empty_slot = (slot_q == SLW'(NSLOT - 1));
  assign cur_reg    = slot_reg(slot_q, op_q);

  // Initial work mask: low registers, extra slot, or empty-mask slot.
  always_comb begin
    pend_init = '0;
    if (op[1] && reg_list == '0) begin
      pend_init[NSLOT-1] = 1'b1;
    end else begin
      pend_init[NLOW-1:0] = reg_list;
      pend_init[NLOW]     = !op[1] && xtra;
    end
  end

  blkxfer_pick #(.N(NSLOT), .IW(SLW)) u_pick (
    .pend (pend),
    .down (op_q == OP_PUSH),
    .any  (pick_any),
    .idx  (pick_idx)
  );

  blkxfer_addr #(.XLEN(XLEN)) u_addr (
    .op         (op_q),
    .ptr        (ptr),
    .empty_slot (empty_slot),
    .acc_addr   (acc_addr),
    .ptr_nxt    (ptr_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= S_IDLE;
      op_q       <= OP_PUSH;
      pend       <= '0;
      ptr        <= '0;
      pc_q       <= '0;
      first_q    <= 1'b1;
      wb_en_q    <= 1'b0;
      wb_idx_q   <= '0;
      slot_q     <= '0;
      busy       <= 1'b0;
      mem_valid  <= 1'b0;
      mem_we     <= 1'b0;
      mem_seq    <= 1'b0;
      mem_addr   <= '0;
      mem_wdata  <= '0;
      rf_rd_idx  <= '0;
      rf_we      <= 1'b0;
      rf_wr_idx  <= '0;
      rf_wr_data <= '0;
      flush      <= 1'b0;
      icyc       <= 1'b0;
    end else begin
      rf_we <= 1'b0;
      flush <= 1'b0;
      case (st)
        S_IDLE: begin
          if (start) begin
            op_q     <= xop_e'(op);
            pend     <= pend_init;
            ptr      <= base_val;
            pc_q     <= pc_val;
            first_q  <= 1'b1;
            wb_en_q  <= !(op == OP_LDM && reg_list[base_idx]);
            wb_idx_q <= op[1] ? RIW'(base_idx) : RIW'(IDX_SP);
            busy     <= 1'b1;
            st       <= S_SEL;
          end
        end
        S_SEL: begin
          if (pick_any) begin
            slot_q    <= pick_idx;
            rf_rd_idx <= RIW'(slot_reg(pick_idx, op_q));
            st        <= S_ISSUE;
          end else if (is_ld && !first_q) begin
            icyc <= 1'b1;
            st   <= S_ICYC;
          end else begin
            st <= S_FIN;
          end
        end
        S_ISSUE: begin
          mem_valid <= 1'b1;
          mem_we    <= !is_ld;
          mem_seq   <= !first_q;
          mem_addr  <= acc_addr;
          mem_wdata <= is_ld ? '0 : (empty_slot ? pc_q + XLEN'(2) : rf_rd_data);
          ptr       <= ptr_nxt;
          st        <= S_BUS;
        end
        S_BUS: begin
          if (mem_ready) begin
            mem_valid    <= 1'b0;
            pend[slot_q] <= 1'b0;
            first_q      <= 1'b0;
            if (is_ld) begin
              rf_we     <= 1'b1;
              rf_wr_idx <= RIW'(cur_reg);
              if (cur_reg == IDX_PC) begin
                rf_wr_data <= mem_rdata & ~XLEN'(1);
                flush      <= 1'b1;
              end else begin
                rf_wr_data <= mem_rdata;
              end
            end
            st <= S_SEL;
          end
        end
        S_ICYC: begin
          icyc <= 1'b0;
          st   <= S_FIN;
        end
        S_FIN: begin
          rf_we      <= wb_en_q;
          rf_wr_idx  <= wb_idx_q;
          rf_wr_data <= ptr;
          st         <= S_DONE;
        end
        S_DONE: begin
          busy <= 1'b0;
          st   <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // Stalled request must not move (R10)
  p_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) &&
                                   $stable(mem_wdata) && $stable(mem_we)));

  // Word-aligned requests (R5)
  p_align_r5: assert property (@(posedge clk) disable iff (rst)
    mem_valid |-> (mem_addr[1:0] == 2'b00));

  // Flush accompanies an even PC write (R4)
  p_flush_r4: assert property (@(posedge clk) disable iff (rst)
    flush |-> (rf_we && rf_wr_idx == RIW'(IDX_PC) && !rf_wr_data[0]));

  // Internal cycle is quiet on both ports (R9)
  p_icyc_r9: assert property (@(posedge clk) disable iff (rst)
    icyc |-> (busy && !mem_valid && !rf_we));

  // Nothing happens while idle (R11)
  p_quiet_r11: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (!mem_valid && !rf_we && !icyc));
endmodule

// File: tb/sim_blkxfer_seq.sv
`timescale 1ns/1ps
module sim_blkxfer_seq;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [1:0]  op = 2'b00;
  logic [7:0]  reg_list = 8'h00;
  logic        xtra = 1'b0;
  logic [2:0]  base_idx = 3'd0;
  logic [31:0] base_val = 32'h0, pc_val = 32'h0;
  logic        busy, mem_valid, mem_we, mem_seq, mem_ready;
  logic [31:0] mem_addr, mem_wdata, mem_rdata, rf_rd_data, rf_wr_data;
  logic [3:0]  rf_rd_idx, rf_wr_idx;
  logic        rf_we, flush, icyc;

  always #4 clk = ~clk;   // 125 MHz

  blkxfer_seq u0 (
    .clk(clk), .rst(rst), .start(start), .op(op), .reg_list(reg_list),
    .xtra(xtra), .base_idx(base_idx), .base_val(base_val), .pc_val(pc_val),
    .busy(busy), .mem_valid(mem_valid), .mem_we(mem_we), .mem_seq(mem_seq),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ready(mem_ready),
    .mem_rdata(mem_rdata), .rf_rd_idx(rf_rd_idx), .rf_rd_data(rf_rd_data),
    .rf_we(rf_we), .rf_wr_idx(rf_wr_idx), .rf_wr_data(rf_wr_data),
    .flush(flush), .icyc(icyc)
  );

  function automatic logic [31:0] init_reg(input logic [3:0] i);
    return (i == 4'd14) ? 32'hCAFE_0014 : 32'h1000_0000 + 32'(i);
  endfunction
  function automatic logic [31:0] memv(input logic [31:0] a);
    if (a == 32'h4C) return 32'h0000_2001;
    if (a == 32'h10) return 32'h0000_3003;
    return 32'h5A00_0000 | a;
  endfunction

  // register file and memory models
  logic [31:0] regs [16];
  logic [15:0] wrote = '0;
  logic [1:0]  tick = '0;
  logic        stall_en = 1'b0;
  assign rf_rd_data = wrote[rf_rd_idx] ? regs[rf_rd_idx] : init_reg(rf_rd_idx);
  assign mem_rdata  = memv(mem_addr);
  assign mem_ready  = !stall_en || (tick == 2'b11);

  int nm = 0, nw = 0, nflush = 0, nicyc = 0;
  logic [31:0] la [64];
  logic [31:0] ld [64];
  logic        lwe [64];
  logic        lseq [64];
  logic [3:0]  wi [64];
  logic [31:0] wd [64];
  logic        wbusy [64];

  always @(posedge clk) begin
    tick <= tick + 2'd1;
    if (mem_valid && mem_ready) begin
      la[nm] <= mem_addr; ld[nm] <= mem_wdata; lwe[nm] <= mem_we; lseq[nm] <= mem_seq;
      nm <= nm + 1;
    end
    if (rf_we) begin
      regs[rf_wr_idx] <= rf_wr_data; wrote[rf_wr_idx] <= 1'b1;
      wi[nw] <= rf_wr_idx; wd[nw] <= rf_wr_data; wbusy[nw] <= busy;
      nw <= nw + 1;
    end
    if (flush) nflush <= nflush + 1;
    if (icyc)  nicyc  <= nicyc + 1;
  end

  int checks = 0, errors = 0;
  int m0, w0, f0, i0;

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic chk_mem(input int i, input string req, input logic [31:0] a, input logic we, input logic [31:0] d);
    chk(req, "address", la[m0+i], a);
    chk(req, "write enable", 32'(lwe[m0+i]), 32'(we));
    if (we) chk(req, "write data", ld[m0+i], d);
    chk("R8", "seq flag", 32'(lseq[m0+i]), 32'(i != 0));
  endtask

  task automatic chk_rf(input int i, input string req, input logic [3:0] idx, input logic [31:0] d);
    chk(req, "rf index", 32'(wi[w0+i]), 32'(idx));
    chk(req, "rf data", wd[w0+i], d);
  endtask

  task automatic run(input logic [1:0] o, input logic [7:0] l, input logic x, input logic [2:0] b,
                     input logic [31:0] bv, input logic [31:0] pv, input bit poke);
    @(negedge clk);
    m0 = nm; w0 = nw; f0 = nflush; i0 = nicyc;
    op = o; reg_list = l; xtra = x; base_idx = b; base_val = bv; pc_val = pv; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R11", "busy after start", 32'(busy), 32'd1);
    if (poke) begin
      @(negedge clk);
      op = 2'b11; reg_list = 8'hFF; base_val = 32'h0; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    while (busy) @(negedge clk);
  endtask

  task automatic t_reset;
    chk("R1", "idle outputs", {27'b0, busy, mem_valid, rf_we, flush, icyc}, 32'd0);
  endtask

  task automatic t_push;
    run(2'b00, 8'h85, 1'b1, 3'd0, 32'h100, 32'h0, 1'b0);
    chk("R2", "access count", 32'(nm - m0), 32'd4);
    chk_mem(0, "R2", 32'hFC, 1'b1, 32'hCAFE_0014);
    chk_mem(1, "R2", 32'hF8, 1'b1, 32'h1000_0007);
    chk_mem(2, "R2", 32'hF4, 1'b1, 32'h1000_0002);
    chk_mem(3, "R2", 32'hF0, 1'b1, 32'h1000_0000);
    chk("R2", "write count", 32'(nw - w0), 32'd1);
    chk_rf(0, "R2", 4'd13, 32'hF0);
    chk("R11", "busy during writeback", 32'(wbusy[w0]), 32'd1);
    chk("R9", "no internal cycle on store", 32'(nicyc - i0), 32'd0);
  endtask

  task automatic t_push_unaligned;
    stall_en = 1'b1;
    run(2'b00, 8'h02, 1'b0, 3'd0, 32'h102, 32'h0, 1'b0);
    stall_en = 1'b0;
    chk("R10", "access count under stall", 32'(nm - m0), 32'd1);
    chk_mem(0, "R2", 32'hFC, 1'b1, 32'h1000_0001);
    chk_rf(0, "R2", 4'd13, 32'hFE);
  endtask

  task automatic t_stm;
    run(2'b10, 8'h25, 1'b0, 3'd2, 32'h83, 32'h0, 1'b1);
    chk("R11", "stray start ignored", 32'(nm - m0), 32'd3);
    chk_mem(0, "R5", 32'h80, 1'b1, 32'h1000_0000);
    chk_mem(1, "R5", 32'h84, 1'b1, 32'h1000_0002);
    chk_mem(2, "R5", 32'h88, 1'b1, 32'h1000_0005);
    chk("R5", "write count", 32'(nw - w0), 32'd1);
    chk_rf(0, "R5", 4'd2, 32'h8C);
    repeat (8) @(negedge clk);
    chk("R11", "stays idle", 32'(busy), 32'd0);
  endtask

  task automatic t_pop;
    run(2'b01, 8'h4A, 1'b1, 3'd0, 32'h42, 32'h0, 1'b0);
    chk("R3", "access count", 32'(nm - m0), 32'd4);
    chk_mem(0, "R3", 32'h40, 1'b0, 32'h0);
    chk_mem(1, "R3", 32'h44, 1'b0, 32'h0);
    chk_mem(2, "R3", 32'h48, 1'b0, 32'h0);
    chk_mem(3, "R4", 32'h4C, 1'b0, 32'h0);
    chk("R3", "write count", 32'(nw - w0), 32'd5);
    chk_rf(0, "R3", 4'd1, 32'h5A00_0040);
    chk_rf(1, "R3", 4'd3, 32'h5A00_0044);
    chk_rf(2, "R3", 4'd6, 32'h5A00_0048);
    chk_rf(3, "R4", 4'd15, 32'h0000_2000);
    chk_rf(4, "R3", 4'd13, 32'h50);
    chk("R4", "flush count", 32'(nflush - f0), 32'd1);
    chk("R9", "one internal cycle", 32'(nicyc - i0), 32'd1);
  endtask

  task automatic t_ldm_base;
    run(2'b11, 8'h18, 1'b0, 3'd4, 32'h60, 32'h0, 1'b0);
    chk("R6", "access count", 32'(nm - m0), 32'd2);
    chk_mem(0, "R5", 32'h60, 1'b0, 32'h0);
    chk_mem(1, "R5", 32'h64, 1'b0, 32'h0);
    chk("R6", "no writeback", 32'(nw - w0), 32'd2);
    chk_rf(0, "R6", 4'd3, 32'h5A00_0060);
    chk_rf(1, "R6", 4'd4, 32'h5A00_0064);
    chk("R6", "base holds loaded value", regs[4], 32'h5A00_0064);
    chk("R9", "one internal cycle", 32'(nicyc - i0), 32'd1);
  endtask

  task automatic t_ldm_stall;
    int k;
    stall_en = 1'b1;
    run(2'b11, 8'hFD, 1'b0, 3'd1, 32'h20, 32'h0, 1'b0);
    stall_en = 1'b0;
    chk("R10", "access count under stall", 32'(nm - m0), 32'd7);
    k = 0;
    for (int r = 0; r < 8; r++) begin
      if (r != 1) begin
        chk_mem(k, "R10", 32'h20 + 32'(4 * k), 1'b0, 32'h0);
        chk_rf(k, "R10", 4'(r), 32'h5A00_0020 + 32'(4 * k));
        k++;
      end
    end
    chk_rf(7, "R5", 4'd1, 32'h3C);
  endtask

  task automatic t_empty_ldm;
    run(2'b11, 8'h00, 1'b0, 3'd3, 32'h11, 32'h0, 1'b0);
    chk("R7", "access count", 32'(nm - m0), 32'd1);
    chk_mem(0, "R7", 32'h10, 1'b0, 32'h0);
    chk_rf(0, "R7", 4'd15, 32'h0000_3002);
    chk_rf(1, "R7", 4'd3, 32'h50);
    chk("R7", "flush count", 32'(nflush - f0), 32'd1);
  endtask

  task automatic t_empty_stm;
    run(2'b10, 8'h00, 1'b0, 3'd5, 32'h30, 32'h800, 1'b0);
    chk("R7", "access count", 32'(nm - m0), 32'd1);
    chk_mem(0, "R7", 32'h30, 1'b1, 32'h802);
    chk("R7", "write count", 32'(nw - w0), 32'd1);
    chk_rf(0, "R7", 4'd5, 32'h70);
    chk("R7", "no flush on store", 32'(nflush - f0), 32'd0);
    chk("R9", "no internal cycle on store", 32'(nicyc - i0), 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_push();
    t_push_unaligned();
    t_stm();
    t_pop();
    t_ldm_base();
    t_ldm_stall();
    t_empty_ldm();
    t_empty_stm();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks + 1, errors + 1);
    $finish;
  end
endmodule